// File: doc/BRIEF.md
# Flash Block Erase-and-Verify Sequencer

This block runs the complete erase algorithm for a block-erasable flash array, so that software does not have to time it. Software supplies a block-select mask and an inclusive word-address range, and it confirms that every word in that range was already programmed to zero. It then pulses `start`. The sequencer drives the erase control high for a pulse of fixed length. It then drops that control, enters erase-verify mode and checks the range one word at a time, starting from the lowest address. At each word it writes the dummy pattern of all ones, waits a settling interval and reads the word back.

If a word does not read back as all ones, the sequencer leaves verify mode and applies another erase pulse. The walk then resumes at the word that failed, not at the start of the range. A budget caps the total number of pulses. The operation ends with `done` when the last word passes. It ends with `error` when the budget runs out, when the watchdog input trips, or when a start is refused. Every delay is given in microseconds and converted to clock cycles from a clock-frequency parameter, rounding up.

Top module: `flash_erase_seq`

## Requirements
- R1: A `start` while idle with `preprog_ok` low is refused. The next cycle shows `busy`=0, `error`=1 and `done`=0, and `erase_en` never rises.
- R2: Every erase pulse holds `erase_en` high for exactly PULSE_CYC = ceil(PULSE_US*CLK_HZ/1e6) consecutive cycles. The first pulse starts the cycle after an accepted `start`.
- R3: `erase_en` and `ev_en` are never high in the same cycle. There is at least one cycle with both low when the sequencer switches from one to the other.
- R4: After each rise of `ev_en`, the first `fl_wr` strobe comes exactly FIRST_CYC = ceil(FIRST_US*CLK_HZ/1e6) cycles later.
- R5: Each `fl_wr` lasts one cycle and drives `fl_wdata` to all ones. The following `fl_rd` is on the same `fl_addr`, SETTLE_CYC+1 cycles after the write strobe, where SETTLE_CYC = ceil(SETTLE_US*CLK_HZ/1e6).
- R6: `fl_rdata` is sampled the cycle after `fl_rd`. An all-ones word moves the walk to the next address, in ascending order from `addr_lo`. An all-ones word at `addr_hi` ends the operation with `done`=1 and `error`=0.
- R7: A word that is not all ones drops `ev_en` and starts a new erase pulse. The walk then resumes at the address that failed.
- R8: `pulse_cnt` counts the pulses of the current operation. If a verify fails after MAX_PULSES pulses, no further pulse is issued and the operation ends with `error`=1 and `pulse_cnt`=MAX_PULSES.
- R9: `wdog_trip` while busy forces `erase_en` low in the same cycle. On the next cycle `busy` is 0 and `error` is 1.
- R10: `start` while busy is ignored and the running walk is not disturbed. An accepted `start` clears `done` and `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (while idle) |
| blk_mask | input | NBLK | Blocks selected for erase |
| addr_lo | input | AW | First word address of the walk |
| addr_hi | input | AW | Last word address of the walk |
| preprog_ok | input | 1 | All selected words are already programmed to zero |
| wdog_trip | input | 1 | Watchdog expiry; aborts the operation |
| blk_sel | output | NBLK | Latched block mask, held while busy |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | DW | Flash write data (dummy all ones) |
| fl_wr | output | 1 | Flash write strobe |
| fl_rd | output | 1 | Flash read strobe |
| fl_rdata | input | DW | Flash read data, valid one cycle after `fl_rd` |
| erase_en | output | 1 | Erase control to the array |
| ev_en | output | 1 | Erase-verify mode control |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation completed successfully |
| error | output | 1 | Last operation refused, aborted or out of budget |
| pulse_cnt | output | 12 | Erase pulses used by the current operation |

## Verification
On every cycle, the embedded assertions check that the erase and verify controls are mutually exclusive and that each pulse has the exact length. They also check that every dummy write happens in verify mode and that each read reuses the address of its write. Further properties cover the reaction to a refused start or a watchdog trip, and the rule that neither the pulse budget nor the address walk is ever stepped past its limit. Only the bench's scenarios can show the following, because they need a flash model whose words fail for a set number of pulses: the total pulse count of an operation, the resume-at-failing-word order (seen in the read count), the first-write delay after mode entry, and the done and error outcomes.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PULSE,
    ST_GAP,
    ST_EVWAIT,
    ST_DWR,
    ST_SETTLE,
    ST_RD,
    ST_CMP,
    ST_EXIT
  } fes_state_e;

  // Cycles needed to cover a delay in microseconds, rounded up, never below one.
  function automatic longint fes_cycles(input longint us, input longint hz);
    longint c;
    c = (us * hz + 64'd999_999) / 64'd1_000_000;
    return (c < 1) ? 64'd1 : c;
  endfunction

  function automatic int fes_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/fes_interval_timer.sv
module fes_interval_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (restart)        count <= '0;
    else if (count != '1)    count <= count + 1'b1;
  end
endmodule

// File: rtl/fes_addr_walker.sv
module fes_addr_walker #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          at_last
);
  logic [AW-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      hi_q <= '0;
    end else if (load) begin
      addr <= lo;
      hi_q <= hi;
    end else if (step) begin
      addr <= addr + 1'b1;
    end
  end

  assign at_last = (addr == hi_q);

  p_no_step_past_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !at_last);
endmodule

// File: rtl/fes_pulse_budget.sv
module fes_pulse_budget #(
  parameter int CW  = 12,
  parameter int MAX = 3000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          bump,
  output logic [CW-1:0] count,
  output logic          exhausted
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= bump ? CW'(1) : '0;
    else if (bump)  count <= count + 1'b1;
  end

  assign exhausted = (count >= CW'(MAX));

  p_budget_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !clear) |-> !exhausted);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter longint CLK_HZ     = 16_000_000,
  parameter int     PULSE_US   = 10_000,
  parameter int     SETTLE_US  = 2,
  parameter int     FIRST_US   = 4,
  parameter int     MAX_PULSES = 3000,
  parameter int     AW         = 16,
  parameter int     DW         = 8,
  parameter int     NBLK       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NBLK-1:0] blk_mask,
  input  logic [AW-1:0]   addr_lo,
  input  logic [AW-1:0]   addr_hi,
  input  logic            preprog_ok,
  input  logic            wdog_trip,
  output logic [NBLK-1:0] blk_sel,
  output logic [AW-1:0]   fl_addr,
  output logic [DW-1:0]   fl_wdata,
  output logic            fl_wr,
  output logic            fl_rd,
  input  logic [DW-1:0]   fl_rdata,
  output logic            erase_en,
  output logic            ev_en,
  output logic            busy,
  output logic            done,
  output logic            error,
  output logic [11:0]     pulse_cnt
);
  localparam int PULSE_CYC  = int'(fes_cycles(longint'(PULSE_US),  CLK_HZ));
  localparam int SETTLE_CYC = int'(fes_cycles(longint'(SETTLE_US), CLK_HZ));
  localparam int FIRST_CYC  = int'(fes_cycles(longint'(FIRST_US),  CLK_HZ));
  localparam int LONGEST    = fes_max3(PULSE_CYC, SETTLE_CYC, FIRST_CYC);
  localparam int TW         = $clog2(LONGEST + 1) + 1;

  fes_state_e state, nxt;
  logic [TW-1:0] tmr, lim_m1;
  logic [AW-1:0] walk_addr;
  logic at_last, exhausted, done_q, err_q;
  logic [NBLK-1:0] blk_q;

  // Named internal events
  logic idle, ev_accept, ev_refuse, ev_abort, tmr_hit, word_ok;
  logic ev_pass_last, ev_step, ev_retry, ev_giveup, bump;

  assign idle         = (state == ST_IDLE);
  assign ev_accept    = idle && start && preprog_ok;
  assign ev_refuse    = idle && start && !preprog_ok;
  assign ev_abort     = !idle && wdog_trip;
  assign word_ok      = (fl_rdata == {DW{1'b1}});
  assign ev_pass_last = (state == ST_CMP) && word_ok && at_last;
  assign ev_step      = (state == ST_CMP) && word_ok && !at_last && !ev_abort;
  assign ev_retry     = (state == ST_EXIT) && !exhausted && !ev_abort;
  assign ev_giveup    = (state == ST_EXIT) && exhausted;
  assign bump         = ev_accept || ev_retry;

  always_comb begin
    case (state)
      ST_PULSE:  lim_m1 = TW'(PULSE_CYC - 1);
      ST_EVWAIT: lim_m1 = TW'(FIRST_CYC - 1);
      ST_SETTLE: lim_m1 = TW'(SETTLE_CYC - 1);
      default:   lim_m1 = '0;
    endcase
  end
  assign tmr_hit = (tmr == lim_m1);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (ev_accept) nxt = ST_PULSE;
      ST_PULSE:  if (tmr_hit) nxt = ST_GAP;
      ST_GAP:    nxt = ST_EVWAIT;
      ST_EVWAIT: if (tmr_hit) nxt = ST_DWR;
      ST_DWR:    nxt = ST_SETTLE;
      ST_SETTLE: if (tmr_hit) nxt = ST_RD;
      ST_RD:     nxt = ST_CMP;
      ST_CMP:    nxt = !word_ok ? ST_EXIT : (at_last ? ST_IDLE : ST_DWR);
      ST_EXIT:   nxt = exhausted ? ST_IDLE : ST_PULSE;
      default:   nxt = ST_IDLE;
    endcase
    if (ev_abort) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      blk_q  <= '0;
    end else begin
      state <= nxt;
      if (ev_accept) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
        blk_q  <= blk_mask;
      end else if (ev_refuse) begin
        done_q <= 1'b0;
        err_q  <= 1'b1;
      end else if (ev_abort || ev_giveup) begin
        err_q  <= 1'b1;
      end else if (ev_pass_last) begin
        done_q <= 1'b1;
      end
    end
  end

  fes_interval_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(nxt != state), .count(tmr)
  );

  fes_addr_walker #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(ev_accept), .lo(addr_lo), .hi(addr_hi),
    .step(ev_step), .addr(walk_addr), .at_last(at_last)
  );

  fes_pulse_budget #(.CW(12), .MAX(MAX_PULSES)) u_budget (
    .clk(clk), .rst_n(rst_n), .clear(ev_accept), .bump(bump),
    .count(pulse_cnt), .exhausted(exhausted)
  );

  assign erase_en = (state == ST_PULSE) && !wdog_trip;
  assign ev_en    = (state == ST_EVWAIT) || (state == ST_DWR) || (state == ST_SETTLE)
                 || (state == ST_RD) || (state == ST_CMP);
  assign fl_wr    = (state == ST_DWR);
  assign fl_rd    = (state == ST_RD);
  assign fl_addr  = walk_addr;
  assign fl_wdata = {DW{1'b1}};
  assign busy     = !idle;
  assign done     = done_q;
  assign error    = err_q;
  assign blk_sel  = busy ? blk_q : '0;

  // Assertion-only monitor of the erase pulse width
  int er_hold;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        er_hold <= 0;
    else if (erase_en) er_hold <= er_hold + 1;
    else               er_hold <= 0;
  end

  p_refuse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refuse |=> (!busy && error && !done));
  p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> (er_hold == PULSE_CYC));
  p_mode_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_en && ev_en));
  p_gap_before_verify_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_en) |-> $past(!erase_en));
  p_dummy_in_verify_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_wr |-> (ev_en && fl_wdata == {DW{1'b1}}));
  p_read_same_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd |-> $stable(fl_addr));
  p_watchdog_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (!busy && error));
endmodule

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4, DW = 8, NBLK = 4;
  localparam int PULSE_CYC = 20, SETTLE_CYC = 3, FIRST_CYC = 5, MAXP = 4;

  logic clk = 0, rst_n = 0, start = 0, preprog_ok = 0, wdog_trip = 0;
  logic [NBLK-1:0] blk_mask = '0, blk_sel;
  logic [AW-1:0] addr_lo = '0, addr_hi = '0, fl_addr;
  logic [DW-1:0] fl_wdata, fl_rdata;
  logic fl_wr, fl_rd, erase_en, ev_en, busy, done, error;
  logic [11:0] pulse_cnt;

  int n_checks = 0, n_fail = 0;
  int need [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_erase_seq #(.CLK_HZ(1_000_000), .PULSE_US(20), .SETTLE_US(3), .FIRST_US(5),
    .MAX_PULSES(MAXP), .AW(AW), .DW(DW), .NBLK(NBLK)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_mask(blk_mask), .addr_lo(addr_lo),
    .addr_hi(addr_hi), .preprog_ok(preprog_ok), .wdog_trip(wdog_trip), .blk_sel(blk_sel),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_wr(fl_wr), .fl_rd(fl_rd),
    .fl_rdata(fl_rdata), .erase_en(erase_en), .ev_en(ev_en), .busy(busy), .done(done),
    .error(error), .pulse_cnt(pulse_cnt));

  // Flash model and protocol monitor
  logic mon_clr = 0;
  int n_pulses, bad_len, overlap, first_bad, n_first, rd_bad, wd_bad, n_reads;
  int er_run, ev_age, wr_age;
  logic ev_first;
  logic [AW-1:0] wr_addr;

  always @(posedge clk) begin
    if (mon_clr) begin
      n_pulses <= 0; bad_len <= 0; overlap <= 0; first_bad <= 0; n_first <= 0;
      rd_bad <= 0; wd_bad <= 0; n_reads <= 0; er_run <= 0; ev_age <= 0; wr_age <= 0;
      ev_first <= 1; fl_rdata <= '0;
    end else begin
      if (erase_en) begin
        if (er_run == 0) n_pulses <= n_pulses + 1;
        er_run <= er_run + 1;
      end else if (er_run != 0) begin
        if (er_run != PULSE_CYC) bad_len <= bad_len + 1;
        er_run <= 0;
      end
      if (erase_en && ev_en) overlap <= overlap + 1;
      if (!ev_en) begin ev_age <= 0; ev_first <= 1; end
      else ev_age <= ev_age + 1;
      if (fl_wr) begin
        if (fl_wdata != '1) wd_bad <= wd_bad + 1;
        if (ev_first) begin
          n_first <= n_first + 1;
          if (ev_age != FIRST_CYC) first_bad <= first_bad + 1;
          ev_first <= 0;
        end
        wr_age <= 1; wr_addr <= fl_addr;
      end else wr_age <= wr_age + 1;
      if (fl_rd) begin
        n_reads <= n_reads + 1;
        if (wr_age != SETTLE_CYC + 1 || wr_addr != fl_addr) rd_bad <= rd_bad + 1;
        fl_rdata <= (n_pulses >= need[fl_addr]) ? 8'hFF : 8'h00;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic prep(input int lo, input int hi, input logic pp);
    for (int i = 0; i < 16; i++) need[i] = 1;
    @(negedge clk); mon_clr = 1; @(negedge clk); mon_clr = 0;
    addr_lo = AW'(lo); addr_hi = AW'(hi); preprog_ok = pp; blk_mask = 4'b0101;
  endtask

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    check(!busy, "timeout", busy, 0);
  endtask

  task automatic t_reset();
    check(!busy && !done && !error, "R1 reset flags", {busy, done, error}, 0);
    check(!erase_en && !ev_en && pulse_cnt == 0, "R3 reset controls", pulse_cnt, 0);
  endtask

  task automatic t_refuse();
    prep(0, 3, 0);
    pulse_start();
    check(!busy && error && !done, "R1 refused start", {busy, error, done}, 3'b010);
    repeat (30) @(negedge clk);
    check(n_pulses == 0, "R1 no pulse", n_pulses, 0);
  endtask

  task automatic t_single();
    prep(2, 5, 1);
    pulse_start();
    check(busy && erase_en && error == 0, "R10 start clears error", error, 0);
    check(blk_sel == 4'b0101, "R10 block mask", blk_sel, 5);
    wait_idle();
    check(done && !error, "R6 done", done, 1);
    check(pulse_cnt == 1 && n_pulses == 1, "R8 one pulse", pulse_cnt, 1);
    check(bad_len == 0, "R2 pulse length", bad_len, 0);
    check(overlap == 0, "R3 no overlap", overlap, 0);
    check(n_first == 1 && first_bad == 0, "R4 first write delay", first_bad, 0);
    check(wd_bad == 0 && rd_bad == 0, "R5 write/settle/read", rd_bad, 0);
    check(n_reads == 4, "R6 walk length", n_reads, 4);
  endtask

  task automatic t_multi();
    prep(0, 7, 1);
    need[3] = 2; need[5] = 3;
    pulse_start();
    repeat (40) @(negedge clk);
    addr_lo = 4'd9; addr_hi = 4'd9;
    pulse_start(); // ignored while busy
    wait_idle();
    check(done && !error, "R7 done after retries", done, 1);
    check(pulse_cnt == 3 && n_pulses == 3, "R7 pulse count", pulse_cnt, 3);
    check(n_reads == 10, "R7 resume at failing word", n_reads, 10);
    check(n_first == 3 && first_bad == 0, "R4 re-entry delay", first_bad, 0);
    check(bad_len == 0 && overlap == 0, "R3 retries clean", overlap, 0);
  endtask

  task automatic t_limit();
    prep(0, 2, 1);
    need[1] = 9;
    pulse_start();
    check(!done, "R10 start clears done", done, 0);
    wait_idle();
    check(error && !done, "R8 budget error", error, 1);
    check(pulse_cnt == MAXP && n_pulses == MAXP, "R8 pulse cap", n_pulses, MAXP);
    repeat (40) @(negedge clk);
    check(n_pulses == MAXP && !erase_en, "R8 no extra pulse", n_pulses, MAXP);
  endtask

  task automatic t_watchdog();
    prep(0, 3, 1);
    pulse_start();
    repeat (5) @(negedge clk);
    wdog_trip = 1; #1;
    check(!erase_en, "R9 erase dropped at once", erase_en, 0);
    @(negedge clk);
    check(!busy && error, "R9 aborted", {busy, error}, 1);
    wdog_trip = 0;
    repeat (30) @(negedge clk);
    check(n_pulses == 1 && !erase_en, "R9 stays stopped", n_pulses, 1);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_refuse();
    t_single();
    t_multi();
    t_limit();
    t_watchdog();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule